// File: doc/BRIEF.md
# Configurable Per-Pin Interrupt Detector

This block watches the already-synchronised levels of a small group of pins, eight by default. It decides for each pin whether an interrupt condition is present. Each pin takes a three-bit trigger code. The code's bits are interleaved across one wide type word: the pin's own bit, the same bit one byte higher, and the same bit two bytes higher. The code selects level-high, level-low, rising-edge, falling-edge or both-edge detection.

Each pin owns a status bit. Edge events set the bit, and it stays set until software writes a one to that pin's clear input. Level conditions are reflected directly, so a clear cannot hold them down while the level is still present. The status bits are ANDed with the per-pin enables and ORed into a single port interrupt request. Status is recorded whether or not the pin is enabled.

Edges are found by comparing each new sample with the sample from the previous cycle. The first cycle after reset only records the pin levels and reports no edge, so pins that are already high at reset do not produce false events.

Top module: `pin_irq_detect`

## Requirements
- R1: For pin n the trigger code is {type[n+16], type[n+8], type[n]}. When type[n+8] is 0 the pin is level-sensitive. Then type[n]=1 selects level-high and type[n]=0 selects level-low, and type[n+16] is not used.
- R2: When type[n+8] is 1 the pin is edge-triggered. type[n+16]=1 means both edges. Otherwise type[n]=1 means rising only and type[n]=0 means falling only. An edge of the other direction leaves the status unchanged.
- R3: A detected edge sets the pin's status bit one clock later. The bit stays set, whatever the pin does afterwards, until it is cleared.
- R4: A 1 on stat_clr[n] while the pin is edge-triggered makes status[n] read 0 after the next clock edge, provided no new edge arrives in that cycle.
- R5: If an accepted edge and a clear for the same pin fall in the same cycle, the edge wins and the status bit is 1 after the clock.
- R6: For a level-sensitive pin, the status bit after a clock edge equals whether its level condition held at that edge. stat_clr has no effect on it while the condition holds.
- R7: port_irq is 1 exactly when some pin has both its status bit and its irq_en bit set. A pin whose enable is 0 still records status.
- R8: While rst is 1, status and port_irq are 0. In the first clock after rst falls, no edge is reported whatever the pin levels are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_level | input | PINS | Synchronised pin levels |
| trig_type | input | 3*PINS | Interleaved trigger codes |
| irq_en | input | PINS | Per-pin interrupt enables |
| stat_clr | input | PINS | Write-1-to-clear pulses for status |
| stat_out | output | PINS | Latched status bits |
| port_irq | output | 1 | Port interrupt request |

## Verification
A new edge on a pin and a clear pulse for the same pin can land in the same cycle. The clear can also arrive while a level-sensitive pin's condition is still active. The bench provokes the first case by raising a rising-edge pin in the very cycle its clear is driven, and expects the status to stay 1 afterwards. It provokes the second case by clearing a level-low pin that is still low, and expects the status to read 1 after the clock. Both cases are also checked per pin by properties on the internal edge-hit and level-active wires.

// File: rtl/pind_pkg.sv
package pind_pkg;

  // code layout per pin: {both_req, edge_sel, dir_or_pol}
  function automatic logic code_is_edge(input logic [2:0] code);
    return code[1];
  endfunction

  function automatic logic code_wants_rise(input logic [2:0] code);
    return code[1] & (code[2] | code[0]);
  endfunction

  function automatic logic code_wants_fall(input logic [2:0] code);
    return code[1] & (code[2] | ~code[0]);
  endfunction

  function automatic logic code_level_active(input logic [2:0] code, input logic lvl);
    return ~code[1] & (code[0] ? lvl : ~lvl);
  endfunction

endpackage

// File: rtl/pind_mode_decode.sv
module pind_mode_decode #(
  parameter int PINS = 8
) (
  input  logic [3*PINS-1:0] trig_type,
  input  logic [PINS-1:0]   pin_level,
  output logic [PINS-1:0]   is_edge,
  output logic [PINS-1:0]   want_rise,
  output logic [PINS-1:0]   want_fall,
  output logic [PINS-1:0]   lvl_act
);
  import pind_pkg::*;

  for (genvar g = 0; g < PINS; g++) begin : g_pin
    logic [2:0] code;
    assign code = {trig_type[g+2*PINS], trig_type[g+PINS], trig_type[g]};
    assign is_edge[g]   = code_is_edge(code);
    assign want_rise[g] = code_wants_rise(code);
    assign want_fall[g] = code_wants_fall(code);
    assign lvl_act[g]   = code_level_active(code, pin_level[g]);
  end
endmodule

// File: rtl/pind_edge_gen.sv
module pind_edge_gen #(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] pin_level,
  input  logic [PINS-1:0] want_rise,
  input  logic [PINS-1:0] want_fall,
  output logic [PINS-1:0] hit
);
  logic [PINS-1:0] prev_q;
  logic            primed_q;
  logic [PINS-1:0] chg;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= pin_level;
      primed_q <= 1'b1;
    end
  end

  assign chg = primed_q ? (pin_level ^ prev_q) : '0;
  assign hit = (chg & pin_level & want_rise) | (chg & ~pin_level & want_fall);
endmodule

// File: rtl/pind_status_reg.sv
module pind_status_reg #(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] is_edge,
  input  logic [PINS-1:0] hit,
  input  logic [PINS-1:0] lvl_act,
  input  logic [PINS-1:0] clr,
  output logic [PINS-1:0] status
);
  logic [PINS-1:0] nxt;

  for (genvar g = 0; g < PINS; g++) begin : g_bit
    always_comb begin
      if (is_edge[g]) nxt[g] = hit[g] | (status[g] & ~clr[g]);
      else            nxt[g] = lvl_act[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= nxt;
  end
endmodule

// File: rtl/pind_irq_combine.sv
module pind_irq_combine #(
  parameter int PINS = 8
) (
  input  logic [PINS-1:0] status,
  input  logic [PINS-1:0] enable,
  output logic            irq
);
  assign irq = |(status & enable);
endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect #(
  parameter int PINS = 8,
  localparam int TW = 3 * PINS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] pin_level,
  input  logic [TW-1:0]   trig_type,
  input  logic [PINS-1:0] irq_en,
  input  logic [PINS-1:0] stat_clr,
  output logic [PINS-1:0] stat_out,
  output logic            port_irq
);
  logic [PINS-1:0] is_edge, want_rise, want_fall, lvl_act, hit;

  pind_mode_decode #(.PINS(PINS)) u_dec (
    .trig_type(trig_type), .pin_level(pin_level), .is_edge(is_edge),
    .want_rise(want_rise), .want_fall(want_fall), .lvl_act(lvl_act));

  pind_edge_gen #(.PINS(PINS)) u_edge (
    .clk(clk), .rst(rst), .pin_level(pin_level),
    .want_rise(want_rise), .want_fall(want_fall), .hit(hit));

  pind_status_reg #(.PINS(PINS)) u_stat (
    .clk(clk), .rst(rst), .is_edge(is_edge), .hit(hit),
    .lvl_act(lvl_act), .clr(stat_clr), .status(stat_out));

  pind_irq_combine #(.PINS(PINS)) u_irq (
    .status(stat_out), .enable(irq_en), .irq(port_irq));
endmodule

// File: rtl/pind_checker.sv
module pind_checker #(
  parameter int PINS = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [3*PINS-1:0] trig_type,
  input logic [PINS-1:0]   irq_en,
  input logic [PINS-1:0]   stat_clr,
  input logic [PINS-1:0]   stat_out,
  input logic              port_irq,
  input logic [PINS-1:0]   hit,
  input logic [PINS-1:0]   lvl_act
);
  assert_reset_quiet_R8: assert property (@(posedge clk) rst |=> (stat_out == '0));

  assert_no_masked_irq_R7: assert property (@(posedge clk) disable iff (rst)
    ((stat_out & irq_en) == '0) |-> !port_irq);

  for (genvar g = 0; g < PINS; g++) begin : g_chk
    assert_edge_hold_R3: assert property (@(posedge clk) disable iff (rst)
      $fell(stat_out[g]) |-> ($past(stat_clr[g]) || !$past(trig_type[g+PINS])));

    assert_edge_wins_R5: assert property (@(posedge clk) disable iff (rst)
      hit[g] |=> stat_out[g]);

    assert_level_follow_R6: assert property (@(posedge clk) disable iff (rst)
      lvl_act[g] |=> stat_out[g]);
  end
endmodule

bind pin_irq_detect pind_checker #(.PINS(PINS)) u_chk (
  .clk(clk), .rst(rst), .trig_type(trig_type), .irq_en(irq_en),
  .stat_clr(stat_clr), .stat_out(stat_out), .port_irq(port_irq),
  .hit(hit), .lvl_act(lvl_act));

// File: tb/sim_pin_irq_detect.sv
module sim_pin_irq_detect;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  pin_level = '0;
  logic [23:0] trig_type;
  logic [7:0]  irq_en = 8'hFF;
  logic [7:0]  stat_clr = '0;
  logic [7:0]  stat_out;
  logic        port_irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pin_irq_detect u0 (.*);

  // codes {hi,mid,lo}: rise 011, fall 010, both 110, level-high 001, level-low 000
  function automatic logic [23:0] build_type(input logic [2:0] c [8]);
    logic [23:0] t = '0;
    for (int i = 0; i < 8; i++) begin
      t[i]      = c[i][0];
      t[i + 8]  = c[i][1];
      t[i + 16] = c[i][2];
    end
    return t;
  endfunction

  // {en, clr, pins, exp_status, exp_irq}
  localparam logic [32:0] VEC [12] = '{
    {8'hFF, 8'h00, 8'h00, 8'h10, 1'b1},
    {8'hFF, 8'h00, 8'hFF, 8'hAD, 1'b1},
    {8'hFF, 8'h00, 8'h00, 8'hF7, 1'b1},
    {8'hFF, 8'hFF, 8'h00, 8'h10, 1'b1},
    {8'hEF, 8'h00, 8'h00, 8'h10, 1'b0},
    {8'hEF, 8'h01, 8'h01, 8'h11, 1'b1},
    {8'hEF, 8'h01, 8'h01, 8'h10, 1'b0},
    {8'h00, 8'h00, 8'h21, 8'h30, 1'b0},
    {8'h20, 8'h00, 8'h21, 8'h30, 1'b1},
    {8'h20, 8'h20, 8'h21, 8'h10, 1'b0},
    {8'h10, 8'h10, 8'h21, 8'h10, 1'b1},
    {8'h10, 8'h00, 8'h31, 8'h00, 1'b0}
  };

  function automatic string row_tag(input int r);
    case (r)
      0: return "R6 level-low after reset";
      1, 2: return "R2 edge kinds";
      3: return "R4 clear edge pins";
      4, 7, 8: return "R7 masking";
      5: return "R5 edge beats clear";
      6, 9: return "R4 clear";
      10: return "R6 clear on active level";
      default: return "R1 level-low release";
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] est, input logic eirq);
    n_run++;
    if (stat_out !== est || port_irq !== eirq) begin
      n_fail++;
      $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
               tag, stat_out, port_irq, est, eirq);
    end
  endtask

  task automatic step(input logic [7:0] en, input logic [7:0] clr, input logic [7:0] pins);
    irq_en = en; stat_clr = clr; pin_level = pins;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [2:0] codes [8];
    codes = '{3'b011, 3'b010, 3'b110, 3'b001, 3'b000, 3'b011, 3'b010, 3'b110};
    trig_type = build_type(codes);
    repeat (3) @(negedge clk);
    check("R8 reset state", 8'h00, 1'b0);
    rst = 1'b0;
    for (int r = 0; r < 12; r++) begin
      step(VEC[r][32:25], VEC[r][24:17], VEC[r][16:9]);
      check(row_tag(r), VEC[r][8:1], VEC[r][0]);
    end
    // reset with pins high, then no phantom edges in first cycle
    rst = 1'b1;
    step(8'hFF, 8'h00, 8'h31);
    check("R8 reset mid-run", 8'h00, 1'b0);
    rst = 1'b0;
    step(8'hFF, 8'h00, 8'h31);
    check("R8 no edge first cycle", 8'h00, 1'b0);
    step(8'hFF, 8'h00, 8'h30);
    check("R2 falling ignored on rise pin", 8'h00, 1'b0);
    // pin 0 becomes level-high; pin 0 currently low, then high
    codes[0] = 3'b001;
    trig_type = build_type(codes);
    step(8'hFF, 8'h00, 8'h31);
    check("R1 level-high after code change", 8'h01, 1'b1);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule